// File: doc/BRIEF.md
# Processor exception entry and return unit

This block holds the control state that a processor core changes when it takes a hardware-failure (machine check) exception or a data-access-violation exception, and when it leaves a machine check handler. It keeps the processor status word, a dedicated save pair for machine checks (saved instruction address and saved status), a second save pair for data-access violations, a sticky syndrome register that accumulates the sources of machine checks, an address register for machine checks that report one, and the vector base register.

On every cycle at most one event is accepted. A machine check beats a return, and a return beats a data-access violation. The chosen event updates all affected registers on one clock edge. On that same edge a one-cycle redirect strobe rises together with the new fetch address. Entry vectors are formed from the upper bits of the vector base with a fixed per-exception low offset. Software may write the status word and the vector base, and may clear syndrome bits by writing ones.

Top module: `exc_entry_unit`

## Requirements
- R1: After a synchronous reset every register output, the fetch address and the redirect strobe read zero.
- R2: A machine check request loads the saved machine-check address with the current instruction address and the saved machine-check status with the status word from before the event. It also sets the fetch address to {vector base, 0x10}.
- R3: On a machine check the status word clears bits 0 to 7 and 9 to 13 (mask 0x3EFF) and keeps all other bits. Bit 8 (debug enable) is cleared only when the clear-debug configuration input is 1.
- R4: The syndrome register ORs in the source vector of each machine check, and hardware never clears a set syndrome bit.
- R5: A one in the syndrome clear input clears that bit on the next edge, unless a machine check sets the same bit in that cycle, in which case the bit reads one.
- R6: The machine-check address register loads the supplied address only on a machine check whose address-valid input is 1. Otherwise it holds.
- R7: An accepted data-access violation loads the data save address with the faulting effective address and the data save status with the prior status word. It clears status mask 0x3E7F, so bits 7 and 8 are kept, and sets the fetch address to {vector base, 0x20}. The machine-check save registers do not change.
- R8: A data-access violation is dropped, with no register change and no strobe, when a machine check, a return, or the higher-priority-pending input is active in the same cycle.
- R9: A return with no machine check in the same cycle restores the status word from the saved machine-check status and sets the fetch address to the saved machine-check address.
- R10: The redirect strobe is high for exactly the one cycle after each accepted entry or return, and low after a cycle with no accepted event.
- R11: A status write takes effect only in a cycle with no accepted event. A vector base write always takes effect, and the vector formed in that same cycle uses the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc_i | input | ADDR_W | Address of the instruction in flight |
| mc_req_i | input | 1 | Machine check request |
| mc_src_i | input | SYN_W | Machine check source bits |
| mc_addr_vld_i | input | 1 | Machine check carries an address |
| mc_addr_i | input | ADDR_W | Address associated with the machine check |
| ds_req_i | input | 1 | Data-access violation request |
| ds_ea_i | input | ADDR_W | Faulting effective address |
| hi_pend_i | input | 1 | A higher-priority exception is pending |
| mc_ret_i | input | 1 | Return-from-machine-check strobe |
| cfg_mc_clr_dbg_i | input | 1 | Clear debug enable on machine check entry |
| stat_wr_en_i | input | 1 | Software status write enable |
| stat_wr_val_i | input | STAT_W | Software status write value |
| vbase_wr_en_i | input | 1 | Vector base write enable |
| vbase_wr_val_i | input | BASE_W | Vector base write value |
| syn_clr_i | input | SYN_W | Syndrome write-one-to-clear bits |
| redirect_o | output | 1 | Fetch redirect strobe |
| fetch_addr_o | output | ADDR_W | Redirect target address |
| stat_o | output | STAT_W | Processor status word |
| mc_save_pc_o | output | ADDR_W | Machine check saved address |
| mc_save_stat_o | output | STAT_W | Machine check saved status |
| ds_save_pc_o | output | ADDR_W | Data-access saved address |
| ds_save_stat_o | output | STAT_W | Data-access saved status |
| syndrome_o | output | SYN_W | Machine check syndrome |
| mc_addr_o | output | ADDR_W | Machine check address |
| vbase_o | output | BASE_W | Vector base |

## Verification
Every register is a port, so a wrong update shows at the outputs on the edge that follows the stimulus. A bad priority decision shows as a changed save register or a stray redirect in that same cycle. A lost syndrome bit or a restore from the wrong save pair stays visible until software writes over it. A lost bit is therefore seen one cycle after the event, and a compare on every cycle cannot miss it.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // status word bit positions
  localparam int B_RECOV     = 0;
  localparam int B_PERF_MASK = 1;
  localparam int B_DSPACE    = 2;
  localparam int B_ISPACE    = 3;
  localparam int B_FPEXC1    = 4;
  localparam int B_FPEXC0    = 5;
  localparam int B_FPU_EN    = 6;
  localparam int B_MCHK_EN   = 7;
  localparam int B_DBG_EN    = 8;
  localparam int B_USER      = 9;
  localparam int B_EXT_EN    = 10;
  localparam int B_CRIT_EN   = 11;
  localparam int B_WAIT_EN   = 12;
  localparam int B_VEC_EN    = 13;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_MCHK  = 2'd1,
    EV_RET   = 2'd2,
    EV_DSTOR = 2'd3
  } exc_event_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic       mc_req_i,
  input  logic       ret_req_i,
  input  logic       ds_req_i,
  input  logic       hi_pend_i,
  output exc_event_e ev_o
);
  always_comb begin
    if (mc_req_i)                    ev_o = EV_MCHK;
    else if (ret_req_i)              ev_o = EV_RET;
    else if (ds_req_i && !hi_pend_i) ev_o = EV_DSTOR;
    else                             ev_o = EV_NONE;
  end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_pkg::*;
#(
  parameter int          STAT_W   = 32,
  parameter logic [STAT_W-1:0] STAT_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  exc_event_e        ev_i,
  input  logic              clr_dbg_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_val_i,
  input  logic [STAT_W-1:0] restore_i,
  output logic [STAT_W-1:0] stat_o
);
  function automatic logic [STAT_W-1:0] bit_of(int idx);
    logic [STAT_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] DS_MASK =
    bit_of(B_RECOV) | bit_of(B_PERF_MASK) | bit_of(B_DSPACE) | bit_of(B_ISPACE) |
    bit_of(B_FPEXC1) | bit_of(B_FPEXC0) | bit_of(B_FPU_EN) | bit_of(B_USER) |
    bit_of(B_EXT_EN) | bit_of(B_CRIT_EN) | bit_of(B_WAIT_EN) | bit_of(B_VEC_EN);
  localparam logic [STAT_W-1:0] MC_MASK  = DS_MASK | bit_of(B_MCHK_EN);
  localparam logic [STAT_W-1:0] DBG_MASK = bit_of(B_DBG_EN);

  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mc_clear;

  assign mc_clear = MC_MASK | (clr_dbg_i ? DBG_MASK : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= STAT_RST;
    end else begin
      unique case (ev_i)
        EV_MCHK:  stat_q <= stat_q & ~mc_clear;
        EV_DSTOR: stat_q <= stat_q & ~DS_MASK;
        EV_RET:   stat_q <= restore_i;
        default:  if (wr_en_i) stat_q <= wr_val_i;
      endcase
    end
  end

  assign stat_o = stat_q;

  AST_MC_DBG_KEPT: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_MCHK && !clr_dbg_i) |=> stat_q[B_DBG_EN] == $past(stat_q[B_DBG_EN])); // R3
  AST_MC_DBG_CLR: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_MCHK && clr_dbg_i) |=> !stat_q[B_DBG_EN]); // R3
  AST_DS_KEEPS_MCHK: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_DSTOR) |=> stat_q[B_MCHK_EN] == $past(stat_q[B_MCHK_EN])); // R7
endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome #(
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic [SYN_W-1:0] set_i,
  input  logic [SYN_W-1:0] clr_i,
  output logic [SYN_W-1:0] syn_o
);
  logic [SYN_W-1:0] syn_q;

  for (genvar b = 0; b < SYN_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      syn_q[b] <= 1'b0;
      else if (set_en_i && set_i[b]) syn_q[b] <= 1'b1;
      else if (clr_i[b])            syn_q[b] <= 1'b0;
    end
  end

  assign syn_o = syn_q;

  AST_SYN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (clr_i == '0) |=> ((syn_q & $past(syn_q)) == $past(syn_q))); // R4
  AST_SYN_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((syn_q & $past(set_i)) == $past(set_i))); // R5
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int SYN_W  = 8,
  parameter int BASE_W = 24,
  parameter logic [ADDR_W-BASE_W-1:0] MC_OFS = 'h10,
  parameter logic [ADDR_W-BASE_W-1:0] DS_OFS = 'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic              mc_req_i,
  input  logic [SYN_W-1:0]  mc_src_i,
  input  logic              mc_addr_vld_i,
  input  logic [ADDR_W-1:0] mc_addr_i,
  input  logic              ds_req_i,
  input  logic [ADDR_W-1:0] ds_ea_i,
  input  logic              hi_pend_i,
  input  logic              mc_ret_i,
  input  logic              cfg_mc_clr_dbg_i,
  input  logic              stat_wr_en_i,
  input  logic [STAT_W-1:0] stat_wr_val_i,
  input  logic              vbase_wr_en_i,
  input  logic [BASE_W-1:0] vbase_wr_val_i,
  input  logic [SYN_W-1:0]  syn_clr_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [ADDR_W-1:0] mc_save_pc_o,
  output logic [STAT_W-1:0] mc_save_stat_o,
  output logic [ADDR_W-1:0] ds_save_pc_o,
  output logic [STAT_W-1:0] ds_save_stat_o,
  output logic [SYN_W-1:0]  syndrome_o,
  output logic [ADDR_W-1:0] mc_addr_o,
  output logic [BASE_W-1:0] vbase_o
);
  exc_event_e        ev;
  logic [STAT_W-1:0] stat;
  logic [ADDR_W-1:0] mc_pc_q, ds_pc_q, mc_addr_q, fetch_q;
  logic [STAT_W-1:0] mc_stat_q, ds_stat_q;
  logic [BASE_W-1:0] vbase_q;
  logic              redirect_q;

  exc_arbiter u_arb (
    .mc_req_i  (mc_req_i),
    .ret_req_i (mc_ret_i),
    .ds_req_i  (ds_req_i),
    .hi_pend_i (hi_pend_i),
    .ev_o      (ev)
  );

  exc_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (ev),
    .clr_dbg_i (cfg_mc_clr_dbg_i),
    .wr_en_i   (stat_wr_en_i),
    .wr_val_i  (stat_wr_val_i),
    .restore_i (mc_stat_q),
    .stat_o    (stat)
  );

  exc_syndrome #(.SYN_W(SYN_W)) u_syn (
    .clk      (clk),
    .rst      (rst),
    .set_en_i (ev == EV_MCHK),
    .set_i    (mc_src_i),
    .clr_i    (syn_clr_i),
    .syn_o    (syndrome_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_pc_q    <= '0;
      mc_stat_q  <= '0;
      ds_pc_q    <= '0;
      ds_stat_q  <= '0;
      mc_addr_q  <= '0;
      fetch_q    <= '0;
      vbase_q    <= '0;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= (ev != EV_NONE);
      if (vbase_wr_en_i) vbase_q <= vbase_wr_val_i;
      unique case (ev)
        EV_MCHK: begin
          mc_pc_q   <= cur_pc_i;
          mc_stat_q <= stat;
          fetch_q   <= {vbase_q, MC_OFS};
          if (mc_addr_vld_i) mc_addr_q <= mc_addr_i;
        end
        EV_DSTOR: begin
          ds_pc_q   <= ds_ea_i;
          ds_stat_q <= stat;
          fetch_q   <= {vbase_q, DS_OFS};
        end
        EV_RET: fetch_q <= mc_pc_q;
        default: ;
      endcase
    end
  end

  assign redirect_o     = redirect_q;
  assign fetch_addr_o   = fetch_q;
  assign stat_o         = stat;
  assign mc_save_pc_o   = mc_pc_q;
  assign mc_save_stat_o = mc_stat_q;
  assign ds_save_pc_o   = ds_pc_q;
  assign ds_save_stat_o = ds_stat_q;
  assign mc_addr_o      = mc_addr_q;
  assign vbase_o        = vbase_q;

  AST_MC_SAVES_STATUS: assert property (@(posedge clk) disable iff (rst)
    mc_req_i |=> mc_save_stat_o == $past(stat_o)); // R2
  AST_MC_VECTOR: assert property (@(posedge clk) disable iff (rst)
    mc_req_i |=> fetch_addr_o == {$past(vbase_o), MC_OFS}); // R2
  AST_MC_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(mc_req_i && mc_addr_vld_i) |=> $stable(mc_addr_o)); // R6
  AST_DS_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (mc_req_i || mc_ret_i || hi_pend_i) |=> $stable(ds_save_pc_o) && $stable(ds_save_stat_o)); // R8
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (mc_ret_i && !mc_req_i) |=> stat_o == $past(mc_save_stat_o) && fetch_addr_o == $past(mc_save_pc_o)); // R9
  AST_REDIRECT_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    (mc_req_i || mc_ret_i) |=> redirect_o); // R10
  AST_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(mc_req_i || mc_ret_i || ds_req_i) |=> !redirect_o); // R10
endmodule

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, SW = 32, YW = 8, BW = 24;
  localparam logic [31:0] MC_MASK = 32'h0000_3EFF;
  localparam logic [31:0] DS_MASK = 32'h0000_3E7F;
  localparam logic [31:0] DBG_BIT = 32'h0000_0100;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst;
  logic [AW-1:0] cur_pc, mc_addr, ds_ea;
  logic mc_req, mc_addr_vld, ds_req, hi_pend, mc_ret, cfg_clr, stat_wr_en, vbase_wr_en;
  logic [YW-1:0] mc_src, syn_clr;
  logic [SW-1:0] stat_wr_val;
  logic [BW-1:0] vbase_wr_val;
  logic redirect;
  logic [AW-1:0] fetch, mc_pc_o, ds_pc_o, mc_addr_o;
  logic [SW-1:0] stat_o, mc_stat_o, ds_stat_o;
  logic [YW-1:0] syn_o;
  logic [BW-1:0] vbase_o;

  exc_entry_unit uut (
    .clk(clk), .rst(rst), .cur_pc_i(cur_pc), .mc_req_i(mc_req), .mc_src_i(mc_src),
    .mc_addr_vld_i(mc_addr_vld), .mc_addr_i(mc_addr), .ds_req_i(ds_req), .ds_ea_i(ds_ea),
    .hi_pend_i(hi_pend), .mc_ret_i(mc_ret), .cfg_mc_clr_dbg_i(cfg_clr),
    .stat_wr_en_i(stat_wr_en), .stat_wr_val_i(stat_wr_val), .vbase_wr_en_i(vbase_wr_en),
    .vbase_wr_val_i(vbase_wr_val), .syn_clr_i(syn_clr), .redirect_o(redirect),
    .fetch_addr_o(fetch), .stat_o(stat_o), .mc_save_pc_o(mc_pc_o), .mc_save_stat_o(mc_stat_o),
    .ds_save_pc_o(ds_pc_o), .ds_save_stat_o(ds_stat_o), .syndrome_o(syn_o),
    .mc_addr_o(mc_addr_o), .vbase_o(vbase_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state
  logic [31:0] e_stat, e_mcpc, e_mcstat, e_dspc, e_dsstat, e_mcaddr, e_fetch;
  logic [7:0]  e_syn;
  logic [23:0] e_vbase;
  logic        e_redir;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    mc_req = 0; mc_src = '0; mc_addr_vld = 0; mc_addr = '0; ds_req = 0; ds_ea = '0;
    hi_pend = 0; mc_ret = 0; cfg_clr = 0; stat_wr_en = 0; stat_wr_val = '0;
    vbase_wr_en = 0; vbase_wr_val = '0; syn_clr = '0; cur_pc = '0;
  endtask

  function automatic logic [31:0] vec(logic [23:0] b, logic [7:0] ofs);
    return {b, ofs};
  endfunction

  task automatic predict();
    bit mc, ret, ds;
    mc  = mc_req;
    ret = !mc && mc_ret;
    ds  = !mc && !ret && ds_req && !hi_pend;
    e_redir = mc | ret | ds;
    e_syn = (e_syn & ~syn_clr) | (mc ? mc_src : 8'h00);
    if (mc) begin
      e_mcpc = cur_pc; e_mcstat = e_stat;
      e_stat = e_stat & ~MC_MASK & ~(cfg_clr ? DBG_BIT : 32'h0);
      e_fetch = vec(e_vbase, 8'h10);
      if (mc_addr_vld) e_mcaddr = mc_addr;
    end else if (ret) begin
      e_stat = e_mcstat; e_fetch = e_mcpc;
    end else if (ds) begin
      e_dspc = ds_ea; e_dsstat = e_stat;
      e_stat = e_stat & ~DS_MASK;
      e_fetch = vec(e_vbase, 8'h20);
    end else if (stat_wr_en) begin
      e_stat = stat_wr_val;
    end
    if (vbase_wr_en) e_vbase = vbase_wr_val;
  endtask

  task automatic compare_all();
    chk("R3", "status", stat_o, e_stat);
    chk("R2", "mc_save_pc", mc_pc_o, e_mcpc);
    chk("R2", "mc_save_stat", mc_stat_o, e_mcstat);
    chk("R7", "ds_save_pc", ds_pc_o, e_dspc);
    chk("R7", "ds_save_stat", ds_stat_o, e_dsstat);
    chk("R4", "syndrome", syn_o, e_syn);
    chk("R6", "mc_addr", mc_addr_o, e_mcaddr);
    chk("R9", "fetch", fetch, e_fetch);
    chk("R10", "redirect", redirect, e_redir);
    chk("R11", "vbase", vbase_o, e_vbase);
  endtask

  task automatic step();
    predict();
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);
    idle_in();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    e_stat = '0; e_mcpc = '0; e_mcstat = '0; e_dspc = '0; e_dsstat = '0;
    e_mcaddr = '0; e_fetch = '0; e_syn = '0; e_vbase = '0; e_redir = 0;
    // R1: reset state
    chk("R1", "reset status", stat_o, 0);
    chk("R1", "reset redirect", redirect, 0);
    chk("R1", "reset fetch", fetch, 0);
    chk("R1", "reset syndrome", syn_o, 0);

    // R11: status and base writes in idle cycle
    stat_wr_en = 1; stat_wr_val = 32'hFFFF_FFFF; vbase_wr_en = 1; vbase_wr_val = 24'hABCDE0;
    step();
    chk("R11", "status write", stat_o, 32'hFFFF_FFFF);

    // R2 R3: machine check without debug clear, base written same cycle
    mc_req = 1; cur_pc = 32'h0000_4444; mc_src = 8'h05; syn_clr = 8'hFF;
    mc_addr_vld = 1; mc_addr = 32'hDEAD_0000; vbase_wr_en = 1; vbase_wr_val = 24'h123456;
    step();
    chk("R3", "mc no dbg clear", stat_o, 32'hFFFF_C100);
    chk("R2", "mc vector old base", fetch, 32'hABCD_E010);
    chk("R5", "set beats clear", syn_o, 8'h05);
    chk("R10", "redirect after mc", redirect, 1);
    step();
    chk("R10", "redirect one cycle", redirect, 0);

    // R5: clear one bit
    syn_clr = 8'h01;
    step();
    chk("R5", "w1c clears", syn_o, 8'h04);

    // R3: machine check with debug clear; R6 no address
    stat_wr_en = 1; stat_wr_val = 32'hFFFF_FFFF;
    step();
    mc_req = 1; cfg_clr = 1; cur_pc = 32'h0000_8888; mc_src = 8'h80;
    stat_wr_en = 1; stat_wr_val = 32'h0;  // ignored, R11
    step();
    chk("R3", "mc dbg clear", stat_o, 32'hFFFF_C000);
    chk("R6", "mc_addr held", mc_addr_o, 32'hDEAD_0000);
    chk("R4", "syndrome accumulates", syn_o, 8'h84);

    // R8: data violation dropped by machine check and by pending
    ds_req = 1; ds_ea = 32'h1111_1111; mc_req = 1; cur_pc = 32'h0000_9999;
    step();
    chk("R8", "ds lost to mc", ds_pc_o, 32'h0);
    ds_req = 1; ds_ea = 32'h2222_2222; hi_pend = 1;
    step();
    chk("R8", "ds dropped pending", ds_pc_o, 32'h0);
    chk("R8", "no redirect", redirect, 0);

    // R7: accepted data violation
    stat_wr_en = 1; stat_wr_val = 32'hFFFF_FFFF;
    step();
    ds_req = 1; ds_ea = 32'h3333_3330; stat_wr_en = 1; stat_wr_val = 32'h0;
    step();
    chk("R7", "ds save pc", ds_pc_o, 32'h3333_3330);
    chk("R7", "ds status", stat_o, 32'hFFFF_C180);
    chk("R7", "ds vector", fetch, 32'h1234_5620);

    // R9: return
    mc_ret = 1;
    step();
    chk("R9", "return fetch", fetch, 32'h0000_9999);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      mc_req      = ($urandom % 8) == 0;
      mc_src      = 8'($urandom);
      mc_addr_vld = $urandom % 2;
      mc_addr     = $urandom;
      ds_req      = ($urandom % 3) == 0;
      ds_ea       = $urandom;
      hi_pend     = ($urandom % 4) == 0;
      mc_ret      = ($urandom % 8) == 0;
      cfg_clr     = $urandom % 2;
      stat_wr_en  = ($urandom % 4) == 0;
      stat_wr_val = $urandom;
      vbase_wr_en = ($urandom % 8) == 0;
      vbase_wr_val = 24'($urandom);
      syn_clr     = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      cur_pc      = $urandom;
      step();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule